// File: doc/BRIEF.md
# SPI Master Serial Engine

This block is the bit-level core of an SPI master. It takes one transmit word at a time from a ready/valid input and shifts it out on `mosi`. At the same time it samples `miso` and hands each received word to a ready/valid output. The serial clock comes from a reload timer: every half period lasts `cfgBaud + 1` module clocks. The word length can be anything from 1 to 32 bits. Bit order, clock polarity, clock phase and the idle level of the data line are all configurable. The transmitter and the receiver can each be switched off on their own.

With the transmitter off and the receiver on, the engine produces no clock until a nonzero byte count is loaded through the receive request input. It then clocks in words back to back. A word carries the configured length while enough bytes remain; the last word is cut to the remaining whole bytes. The remaining count drops to zero and the clock stops. Every received word is right-justified and carries the number of valid bytes it holds. Configuration is captured when a word starts, so changes made during a word take effect at the next one.

Top module: `spi_serial_engine`

## Requirements
- R1: `cfgLenM1` holds the word length minus one, so each word shifts exactly `cfgLenM1 + 1` bits (1 to 32), taken from bits `[N-1:0]` of `txData`.
- R2: Every half period of `sclk` lasts `cfgBaud + 1` clocks. `busy` stays high for exactly `2·N·(cfgBaud+1)` clocks per word.
- R3: With `cfgPhase = 1`, the first data bit is on `mosi` before the first clock edge, and `miso` is sampled on leading edges. With `cfgPhase = 0`, `mosi` holds the idle level until the leading edge changes it, and `miso` is sampled on trailing edges.
- R4: `sclk` rests at `cfgCpol` whenever no word is being shifted.
- R5: With `cfgMsbFirst = 1` the most significant bit goes first, and with 0 the least significant bit goes first. The received word sits in `rxData[N-1:0]` with all higher bits zero.
- R6: `mosi` equals `cfgIdle` while no word is being shifted, and for the whole word when the transmitter is off.
- R7: With `cfgTxOff = 1`, `txReady` stays low. The clock runs only while the remaining byte count is nonzero. A request on `rxReqValid` loads `rxReqBytes` only when the remaining count is zero and is ignored otherwise.
- R8: In receive-only mode with full word size B = ceil(N/8) bytes, a word uses N bits when at least B bytes remain, and otherwise uses 8 bits per remaining byte. `rxRemain` drops by the word's byte count when the word ends, and no clock runs once it reaches zero.
- R9: `rxByteValid` equals the number of bytes the received word occupies (1 to 4), which is ceil(bits/8).
- R10: With `cfgRxOff = 1`, no received word is presented (`rxValid` stays low) while transmission proceeds normally.
- R11: `busy` is high exactly while a word is shifting, and `txReady` is high only while the engine is idle.
- R12: Configuration inputs that change while `busy` is high do not affect the word in progress.
- R13: A received word stays on `rxData` with `rxValid` high until `rxReady`. While the receiver is on, no new word starts during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgLenM1 | input | 5 | Word length minus one |
| cfgMsbFirst | input | 1 | 1: MSB first, 0: LSB first |
| cfgCpol | input | 1 | Serial clock resting level |
| cfgPhase | input | 1 | 1: sample on leading edge, 0: sample on trailing edge |
| cfgIdle | input | 1 | Data output level when not shifting |
| cfgTxOff | input | 1 | Transmitter disabled |
| cfgRxOff | input | 1 | Receiver disabled |
| cfgBaud | input | BAUD_W | Half-period reload value |
| txData | input | 32 | Transmit word, right-justified |
| txValid | input | 1 | Transmit word available |
| txReady | output | 1 | Transmit word accepted on this clock if valid |
| rxReqValid | input | 1 | Load receive byte count |
| rxReqBytes | input | CNT_W | Receive byte count to load |
| rxRemain | output | CNT_W | Bytes still to be received in receive-only mode |
| rxData | output | 32 | Received word, right-justified |
| rxByteValid | output | 3 | Valid bytes in rxData |
| rxValid | output | 1 | Received word available |
| rxReady | input | 1 | Received word consumed |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | Word being shifted |

## Verification
The hardest case to reach from the ports is the end of a receive-only burst. The final word must shrink to the remaining bytes, the count must land exactly on zero, and a new request arriving mid-burst must be ignored. The bench gets there by choosing byte counts that are not multiples of the word's byte size for several word lengths. It pulses the request input partway through the first word and then watches for any clock after the count empties. A second hard case is holding a received word against back-pressure while a transmit word is waiting. The bench reaches it by dropping `rxReady` and keeping `txValid` high.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = $clog2(WORD_W);
  localparam int BIT_W  = LEN_W + 1;
  localparam int EDGE_W = $clog2(2 * WORD_W) + 1;
  localparam int BYTE_W = $clog2(WORD_W / 8) + 1;

  typedef struct packed {
    logic [LEN_W-1:0] lenM1;
    logic             msbFirst;
    logic             cpol;
    logic             phase;
    logic             idleLvl;
    logic             txOff;
    logic             rxOff;
  } mode_t;

  // control -> datapath strobes and latched word settings
  typedef struct packed {
    logic              start;
    logic              sample;
    logic              done;
    logic              busy;
    logic              msbFirst;
    logic              cpol;
    logic              phase;
    logic              idleLvl;
    logic              txOff;
    logic              rxOff;
    logic [EDGE_W-1:0] edgeCnt;
    logic [BIT_W-1:0]  wordBits;
    logic [BYTE_W-1:0] wordBytes;
  } ctl_t;
endpackage

// File: rtl/spi_eng_ctrl.sv
module spi_eng_ctrl
  import spi_eng_pkg::*;
#(
  parameter int BAUD_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  mode_t             modeIn,
  input  logic [BAUD_W-1:0] baudIn,
  input  logic              txValid,
  input  logic              rxHeld,
  input  logic              rxReqValid,
  input  logic [CNT_W-1:0]  rxReqBytes,
  output logic              txReady,
  output logic [CNT_W-1:0]  rxRemain,
  output ctl_t              ctl
);
  logic              busyQ, rxOnlyQ;
  logic              msbQ, cpolQ, phaseQ, idleQ, txOffQ, rxOffQ;
  logic [BAUD_W-1:0] baudQ, timerQ;
  logic [EDGE_W-1:0] edgeQ, lastEdge;
  logic [BIT_W-1:0]  bitsQ, fullBits, nextBits;
  logic [BYTE_W-1:0] bytesQ, fullBytes, nextBytes;
  logic [CNT_W-1:0]  remainQ;
  logic              canStart, txGo, rxGo, partial, start, tick, sample, done;

  assign canStart  = !busyQ && !(rxHeld && !modeIn.rxOff);
  assign txGo      = canStart && !modeIn.txOff && txValid;
  assign rxGo      = canStart && modeIn.txOff && !modeIn.rxOff && (remainQ != '0);
  assign start     = txGo || rxGo;
  assign txReady   = canStart && !modeIn.txOff;

  assign fullBits  = BIT_W'(modeIn.lenM1) + BIT_W'(1);
  assign fullBytes = BYTE_W'(modeIn.lenM1 >> 3) + BYTE_W'(1);
  assign partial   = rxGo && (remainQ < CNT_W'(fullBytes));
  assign nextBits  = partial ? BIT_W'({remainQ[BYTE_W-1:0], 3'b000}) : fullBits;
  assign nextBytes = partial ? remainQ[BYTE_W-1:0] : fullBytes;

  assign lastEdge  = EDGE_W'({bitsQ, 1'b0}) - EDGE_W'(1);
  assign tick      = busyQ && (timerQ == baudQ);
  assign sample    = tick && (edgeQ[0] != phaseQ);
  assign done      = tick && (edgeQ == lastEdge);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0; rxOnlyQ <= 1'b0;
      msbQ <= 1'b0; cpolQ <= 1'b0; phaseQ <= 1'b0; idleQ <= 1'b0;
      txOffQ <= 1'b0; rxOffQ <= 1'b0;
      baudQ <= '0; timerQ <= '0; edgeQ <= '0; bitsQ <= '0; bytesQ <= '0;
    end else if (start) begin
      busyQ   <= 1'b1;
      rxOnlyQ <= rxGo;
      msbQ    <= modeIn.msbFirst;
      cpolQ   <= modeIn.cpol;
      phaseQ  <= modeIn.phase;
      idleQ   <= modeIn.idleLvl;
      txOffQ  <= modeIn.txOff;
      rxOffQ  <= modeIn.rxOff;
      baudQ   <= baudIn;
      timerQ  <= '0;
      edgeQ   <= '0;
      bitsQ   <= nextBits;
      bytesQ  <= nextBytes;
    end else if (busyQ) begin
      if (tick) begin
        timerQ <= '0;
        if (done) begin
          busyQ <= 1'b0;
          edgeQ <= '0;
        end else begin
          edgeQ <= edgeQ + EDGE_W'(1);
        end
      end else begin
        timerQ <= timerQ + BAUD_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) remainQ <= '0;
    else if (rxReqValid && remainQ == '0) remainQ <= rxReqBytes;
    else if (done && rxOnlyQ) remainQ <= remainQ - CNT_W'(bytesQ);
  end

  assign rxRemain = remainQ;

  always_comb begin
    ctl           = '0;
    ctl.start     = start;
    ctl.sample    = sample;
    ctl.done      = done;
    ctl.busy      = busyQ;
    ctl.msbFirst  = msbQ;
    ctl.cpol      = cpolQ;
    ctl.phase     = phaseQ;
    ctl.idleLvl   = idleQ;
    ctl.txOff     = txOffQ;
    ctl.rxOff     = rxOffQ;
    ctl.edgeCnt   = edgeQ;
    ctl.wordBits  = bitsQ;
    ctl.wordBytes = bytesQ;
  end

  AST_EDGE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> edgeQ <= lastEdge); // R1
  AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> timerQ <= baudQ); // R2
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && $past(busyQ)) |-> ($stable(baudQ) && $stable(msbQ) && $stable(phaseQ) && $stable(bitsQ))); // R12
  AST_TXREADY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> !busyQ); // R11
  AST_REMAIN_COVERS: assert property (@(posedge clk) disable iff (!rstN)
    (done && rxOnlyQ) |-> remainQ >= CNT_W'(bytesQ)); // R8
  AST_CLOCK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busyQ) && txOffQ) |-> $past(remainQ) != '0); // R7
endmodule

// File: rtl/spi_eng_datapath.sv
module spi_eng_datapath
  import spi_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic              cpolIn,
  input  logic              idleIn,
  input  logic [WORD_W-1:0] txData,
  input  logic              miso,
  input  logic              rxReady,
  output logic              mosi,
  output logic              sclk,
  output logic [WORD_W-1:0] rxData,
  output logic [BYTE_W-1:0] rxByteValid,
  output logic              rxValid
);
  logic [WORD_W-1:0] txWordQ, rxShQ, rxNext, rxDataQ;
  logic [BYTE_W-1:0] rxBytesQ;
  logic              rxValidQ, driveBit;
  logic [BIT_W-1:0]  sampIdx, txIdx;
  logic [LEN_W-1:0]  sampPos, txPos;

  function automatic logic [LEN_W-1:0] bitPos(input logic [BIT_W-1:0] idx,
                                              input logic [BIT_W-1:0] nBits,
                                              input logic msb);
    logic [BIT_W-1:0] p;
    p = msb ? (nBits - idx - BIT_W'(1)) : idx;
    return p[LEN_W-1:0];
  endfunction

  assign sampIdx  = BIT_W'(ctl.edgeCnt >> 1);
  assign txIdx    = ctl.phase ? BIT_W'(ctl.edgeCnt >> 1)
                              : BIT_W'((ctl.edgeCnt - EDGE_W'(1)) >> 1);
  assign sampPos  = bitPos(sampIdx, ctl.wordBits, ctl.msbFirst);
  assign txPos    = bitPos(txIdx, ctl.wordBits, ctl.msbFirst);
  assign driveBit = ctl.busy && !ctl.txOff && (ctl.phase || ctl.edgeCnt != '0);

  assign mosi = driveBit ? txWordQ[txPos] : (ctl.busy ? ctl.idleLvl : idleIn);
  assign sclk = ctl.busy ? (ctl.cpol ^ ctl.edgeCnt[0]) : cpolIn;

  always_comb begin
    rxNext = rxShQ;
    if (ctl.sample) rxNext[sampPos] = miso;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txWordQ <= '0;
      rxShQ   <= '0;
    end else if (ctl.start) begin
      txWordQ <= txData;
      rxShQ   <= '0;
    end else if (ctl.sample) begin
      rxShQ   <= rxNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxDataQ  <= '0;
      rxBytesQ <= '0;
      rxValidQ <= 1'b0;
    end else if (ctl.done && !ctl.rxOff) begin
      rxDataQ  <= rxNext;
      rxBytesQ <= ctl.wordBytes;
      rxValidQ <= 1'b1;
    end else if (rxReady) begin
      rxValidQ <= 1'b0;
    end
  end

  assign rxData      = rxDataQ;
  assign rxByteValid = rxBytesQ;
  assign rxValid     = rxValidQ;

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rxValidQ && !rxReady) |=> (rxValidQ && $stable(rxDataQ))); // R13
  AST_RX_BYTES: assert property (@(posedge clk) disable iff (!rstN)
    rxValidQ |-> (rxBytesQ != '0 && rxBytesQ <= BYTE_W'(WORD_W / 8))); // R9
  AST_RXOFF_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxValidQ) |-> !ctl.rxOff); // R10
endmodule

// File: rtl/spi_serial_engine.sv
module spi_serial_engine
  import spi_eng_pkg::*;
#(
  parameter int BAUD_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LEN_W-1:0]  cfgLenM1,
  input  logic              cfgMsbFirst,
  input  logic              cfgCpol,
  input  logic              cfgPhase,
  input  logic              cfgIdle,
  input  logic              cfgTxOff,
  input  logic              cfgRxOff,
  input  logic [BAUD_W-1:0] cfgBaud,
  input  logic [WORD_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  input  logic              rxReqValid,
  input  logic [CNT_W-1:0]  rxReqBytes,
  output logic [CNT_W-1:0]  rxRemain,
  output logic [WORD_W-1:0] rxData,
  output logic [BYTE_W-1:0] rxByteValid,
  output logic              rxValid,
  input  logic              rxReady,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              busy
);
  mode_t modeIn;
  ctl_t  ctl;
  logic  rxValidInt;

  assign modeIn = '{lenM1: cfgLenM1, msbFirst: cfgMsbFirst, cpol: cfgCpol,
                    phase: cfgPhase, idleLvl: cfgIdle, txOff: cfgTxOff, rxOff: cfgRxOff};

  spi_eng_ctrl #(.BAUD_W(BAUD_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .modeIn(modeIn), .baudIn(cfgBaud),
    .txValid(txValid), .rxHeld(rxValidInt), .rxReqValid(rxReqValid),
    .rxReqBytes(rxReqBytes), .txReady(txReady), .rxRemain(rxRemain), .ctl(ctl)
  );

  spi_eng_datapath uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cpolIn(cfgCpol), .idleIn(cfgIdle),
    .txData(txData), .miso(miso), .rxReady(rxReady), .mosi(mosi), .sclk(sclk),
    .rxData(rxData), .rxByteValid(rxByteValid), .rxValid(rxValidInt)
  );

  assign rxValid = rxValidInt;
  assign busy    = ctl.busy;
endmodule

// File: tb/sim_spi_serial_engine.sv
module sim_spi_serial_engine;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rstN = 1'b0;
  logic [4:0]  rLenM1 = '0;
  logic        rMsb = 1'b0, rCpol = 1'b0, rPhase = 1'b0, rIdle = 1'b0, rTxOff = 1'b0, rRxOff = 1'b0;
  logic [15:0] rBaud = '0, rxReqBytes = '0, rxRemain;
  logic [31:0] txData = '0, rxData;
  logic        txValid = 1'b0, rxReqValid = 1'b0, rxReady = 1'b1, miso = 1'b0;
  logic        txReady, rxValid, sclk, mosi, busy;
  logic [2:0]  rxByteValid;

  int vectors = 0, fails = 0;
  int capBits = 8, edgeSeen = 0;
  bit capMsb = 1'b0, capPhase = 1'b0, finished = 1'b0;
  logic [31:0] txCap = '0, slaveWord = '0;
  logic lastS = 1'b0, mosiHold = 1'b0;

  spi_serial_engine u0 (
    .clk(clk), .rstN(rstN), .cfgLenM1(rLenM1), .cfgMsbFirst(rMsb), .cfgCpol(rCpol),
    .cfgPhase(rPhase), .cfgIdle(rIdle), .cfgTxOff(rTxOff), .cfgRxOff(rRxOff),
    .cfgBaud(rBaud), .txData(txData), .txValid(txValid), .txReady(txReady),
    .rxReqValid(rxReqValid), .rxReqBytes(rxReqBytes), .rxRemain(rxRemain),
    .rxData(rxData), .rxByteValid(rxByteValid), .rxValid(rxValid), .rxReady(rxReady),
    .sclk(sclk), .mosi(mosi), .miso(miso), .busy(busy)
  );

  always #(CLK_P / 2) clk = ~clk;

  function automatic int posOf(int idx);
    return capMsb ? capBits - 1 - idx : idx;
  endfunction
  function automatic logic bitOf(int idx);
    return (idx < capBits) ? slaveWord[posOf(idx)] : 1'b0;
  endfunction
  function automatic logic [31:0] maskOf(int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  // bench-side slave: records mosi on sampling edges, presents miso bits
  always @(negedge clk) mosiHold = mosi;
  always @(sclk) begin
    if (sclk !== lastS) begin
      if ((edgeSeen % 2) == (capPhase ? 0 : 1) && (edgeSeen / 2) < capBits)
        txCap[posOf(edgeSeen / 2)] = mosiHold;
      edgeSeen++;
    end
    lastS = sclk;
    miso  = bitOf(edgeSeen / 2);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic startCap(input int bits, input bit msb, input bit ph, input logic [31:0] sw);
    capBits = bits; capMsb = msb; capPhase = ph; slaveWord = sw;
    edgeSeen = 0; txCap = '0; lastS = sclk; miso = bitOf(0);
  endtask

  task automatic runWord(input int len, input bit msb, input bit cpol, input bit ph,
                         input int br, input bit rxo, input bit chg,
                         input logic [31:0] tw, input logic [31:0] sw);
    int cyc;
    int expCyc;
    logic [31:0] m;
    m = maskOf(len);
    expCyc = 2 * len * (br + 1);
    @(negedge clk);
    rLenM1 = 5'(len - 1); rMsb = msb; rCpol = cpol; rPhase = ph; rIdle = sw[3];
    rTxOff = 1'b0; rRxOff = rxo; rBaud = 16'(br);
    @(negedge clk);
    chk(sclk == cpol, "R4 idle sclk", 32'(sclk), 32'(cpol));
    chk(mosi == rIdle, "R6 idle mosi", 32'(mosi), 32'(rIdle));
    startCap(len, msb, ph, sw);
    txData = tw; txValid = 1'b1;
    while (!txReady) @(negedge clk);
    @(negedge clk);
    txValid = 1'b0;
    chk(busy == 1'b1 && txReady == 1'b0, "R11 busy after accept", 32'({busy, txReady}), 32'b10);
    if (ph) chk(mosi == tw[msb ? len - 1 : 0], "R3 first bit before edge", 32'(mosi), 32'(tw[msb ? len - 1 : 0]));
    else    chk(mosi == rIdle, "R3 idle before leading edge", 32'(mosi), 32'(rIdle));
    cyc = 0;
    while (busy && cyc < 5000) begin
      if (chg && cyc == 2) begin
        rLenM1 = ~rLenM1; rMsb = ~rMsb; rPhase = ~rPhase; rBaud = rBaud + 16'd3;
      end
      cyc++;
      @(negedge clk);
    end
    chk(cyc == expCyc, chg ? "R12 word length kept" : "R2 word duration", 32'(cyc), 32'(expCyc));
    chk(txCap == (tw & m), chg ? "R12 tx bits kept" : "R1 R5 transmitted bits", txCap, tw & m);
    chk(sclk == cpol, "R4 sclk rests", 32'(sclk), 32'(cpol));
    if (rxo) begin
      chk(rxValid == 1'b0, "R10 no rx word", 32'(rxValid), 32'd0);
    end else begin
      chk(rxValid == 1'b1, "R11 rx word after busy", 32'(rxValid), 32'd1);
      chk(rxData == (sw & m), "R3 R5 received bits", rxData, sw & m);
      chk(32'(rxByteValid) == 32'((len + 7) / 8), "R9 byte count", 32'(rxByteValid), 32'((len + 7) / 8));
    end
  endtask

  task automatic runRx(input int len, input bit msb, input bit ph, input int br, input int req);
    int rem, nb, bits, by, cyc, bad, k;
    logic [31:0] sw;
    bit first;
    @(negedge clk);
    rLenM1 = 5'(len - 1); rMsb = msb; rCpol = 1'b0; rPhase = ph; rIdle = 1'b1;
    rTxOff = 1'b1; rRxOff = 1'b0; rBaud = 16'(br); txValid = 1'b1;
    repeat (4) @(negedge clk);
    chk(txReady == 1'b0 && busy == 1'b0, "R7 no clock without request", 32'({txReady, busy}), 32'd0);
    txValid = 1'b0;
    rem = req; nb = (len + 7) / 8; first = 1'b1; k = 0;
    bits = (rem >= nb) ? len : rem * 8;
    by   = (rem >= nb) ? nb : rem;
    sw = 32'h5A3C_96E1 ^ (32'(len) * 32'h0101_0101);
    startCap(bits, msb, ph, sw);
    rxReqValid = 1'b1; rxReqBytes = 16'(req);
    @(negedge clk);
    rxReqValid = 1'b0;
    chk(rxRemain == 16'(req), "R7 request loaded", 32'(rxRemain), 32'(req));
    while (rem > 0 && k < 64) begin
      while (!busy) @(negedge clk);
      cyc = 0; bad = 0;
      while (busy) begin
        if (mosi !== 1'b1) bad++;
        if (first && cyc == 2) begin rxReqValid = 1'b1; rxReqBytes = 16'd9; end
        else rxReqValid = 1'b0;
        cyc++;
        @(negedge clk);
      end
      rxReqValid = 1'b0;
      rem = rem - by;
      chk(bad == 0, "R6 mosi idle with tx off", 32'(bad), 32'd0);
      chk(cyc == 2 * bits * (br + 1), "R8 rx word length", 32'(cyc), 32'(2 * bits * (br + 1)));
      chk(rxValid == 1'b1 && rxData == (sw & maskOf(bits)), "R5 R8 rx data", rxData, sw & maskOf(bits));
      chk(32'(rxByteValid) == 32'(by), "R9 rx byte count", 32'(rxByteValid), 32'(by));
      chk(rxRemain == 16'(rem), "R7 R8 remaining count", 32'(rxRemain), 32'(rem));
      first = 1'b0; k++;
      if (rem > 0) begin
        bits = (rem >= nb) ? len : rem * 8;
        by   = (rem >= nb) ? nb : rem;
        sw   = {sw[26:0], sw[31:27]} ^ 32'h1357_9BDF;
        startCap(bits, msb, ph, sw);
      end
    end
    bad = 0;
    repeat (20) begin
      if (busy || sclk) bad++;
      @(negedge clk);
    end
    chk(bad == 0 && rxRemain == '0, "R8 clock stops at zero", 32'(bad), 32'd0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && rxValid == 1'b0 && rxRemain == '0, "R11 reset state", 32'({busy, rxValid}), 32'd0);
    chk(sclk == 1'b0 && mosi == 1'b0, "R4 R6 reset outputs", 32'({sclk, mosi}), 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // sweep: every length, every clock mode, both bit orders
    for (int len = 1; len <= 32; len++)
      for (int mode = 0; mode < 4; mode++)
        for (int msb = 0; msb < 2; msb++)
          runWord(len, bit'(msb), bit'(mode >> 1), bit'(mode & 1), (len + mode) % 3, 1'b0, 1'b0,
                  32'h9E37_79B9 * 32'(len * 8 + mode * 2 + msb + 1),
                  ~(32'h7F4A_7C15 * 32'(len + 3 * mode + msb)));

    // transmit-only words
    runWord(13, 1'b1, 1'b0, 1'b1, 1, 1'b1, 1'b0, 32'h0000_1ABC, 32'h0);
    runWord(32, 1'b0, 1'b1, 1'b0, 0, 1'b1, 1'b0, 32'hC0DE_F00D, 32'h0);

    // configuration changed mid-word
    runWord(8, 1'b1, 1'b0, 1'b1, 2, 1'b0, 1'b1, 32'h0000_00A5, 32'h0000_003C);
    runWord(20, 1'b0, 1'b1, 1'b0, 1, 1'b0, 1'b1, 32'h000F_0F0F, 32'h000A_BCDE);

    // receive-only bursts with partial final words
    runRx(16, 1'b1, 1'b1, 0, 5);
    runRx(12, 1'b0, 1'b0, 1, 5);
    runRx(32, 1'b1, 1'b0, 0, 6);
    runRx(8, 1'b0, 1'b1, 2, 3);
    runRx(24, 1'b1, 1'b1, 0, 4);

    // back-pressure on received words
    rxReady = 1'b0;
    runWord(8, 1'b1, 1'b0, 1'b1, 0, 1'b0, 1'b0, 32'h0000_0081, 32'h0000_00C3);
    startCap(8, 1'b1, 1'b1, 32'h0000_0055);
    txData = 32'h0000_00AA; txValid = 1'b1;
    repeat (10) @(negedge clk);
    chk(busy == 1'b0 && txReady == 1'b0, "R13 no start while held", 32'({busy, txReady}), 32'd0);
    chk(rxValid == 1'b1 && rxData == 32'h0000_00C3, "R13 word held", rxData, 32'h0000_00C3);
    rxReady = 1'b1;
    while (!busy) @(negedge clk);
    txValid = 1'b0;
    while (busy) @(negedge clk);
    chk(rxValid == 1'b1 && rxData == 32'h0000_0055, "R13 next word after release", rxData, 32'h0000_0055);
    chk(txCap == 32'h0000_00AA, "R13 waiting word sent", txCap, 32'h0000_00AA);
    repeat (3) @(negedge clk);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule